// File: doc/BRIEF.md
# Banked Register Address Translator

This block turns the 4-bit register number carried in an instruction operand into a 10-bit data-memory address. Two small pieces of state shape the translation: a 3-bit map mode and a 6-bit window base. Each is written by its own control strobe, which takes its value from the low bits of a shared 10-bit control field. Address bit 8 is a mode-selected function of register bits 2 and 3. The mapped value is then XORed with the base shifted left by two. The result is a sliding, banked window onto the register file rather than a plain offset.

An operand may ask for one level of indirection. In that case the block reads data memory through a synchronous read port at the translated address. The low 10 bits of the returned word become the final address. A direct request is answered in the cycle it is presented. An indirect request is answered one cycle later. While the block waits for memory it raises `busy` and ignores new requests.

Top module: `regwin_xlate`

## Requirements
- R1: Before the base is applied, address bits 2:0 equal register bits 2:0, address bit 9 equals register bit 3, and bits 7:3 are zero.
- R2: In map modes 0, 1, 2 and 3, address bit 8 equals register bit 2.
- R3: In map mode 4, address bit 8 equals register bit 3. In map mode 5, it equals the inverse of register bit 3.
- R4: In map mode 6, address bit 8 equals register bit 2 AND bit 3. In map mode 7, it equals bit 2 OR bit 3.
- R5: The final address is the mapped value XORed with the base placed in address bits 7:2. Address bits 1:0, 8 and 9 are not touched by the base.
- R6: `base_ld` loads the base from `ctl_field[5:0]`, and `map_ld` loads the mode from `ctl_field[2:0]`. The remaining field bits are ignored. Without its strobe, each value holds.
- R7: After reset, both base and mode are zero, and no result, memory read or busy is signalled.
- R8: A request with `op_ind`=0 while not busy raises `res_valid` in the same cycle with the translated address, and issues no memory read.
- R9: A request with `op_ind`=1 while not busy raises `mem_rd_en` in the same cycle, with `mem_rd_addr` set to the translated address. In the next cycle, `res_valid` rises with `res_addr` equal to `mem_rd_data[9:0]`.
- R10: During the wait cycle of an indirect request, `busy` is high and any request is ignored: it gives neither a result nor a read.
- R11: A request presented in the same cycle as a base or map load is translated with the values held before that load. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_ld | input | 1 | Load window base from control field |
| map_ld | input | 1 | Load map mode from control field |
| ctl_field | input | 10 | Control instruction immediate field |
| op_req | input | 1 | Operand translation request |
| op_reg | input | 4 | Register number |
| op_ind | input | 1 | Indirect: use memory word as address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 10 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, valid one cycle after strobe |
| res_valid | output | 1 | Final address valid |
| res_addr | output | 10 | Final address |
| busy | output | 1 | Waiting for an indirect read |

## Verification
Two functions can fall in the same cycle: a control load, which changes the base or the map mode, and an operand translation, which reads them. The bench presents a request together with a base load, with a map load, and with both, for direct and for indirect requests. It expects the address computed from the old window, and then a follow-up request that uses the new window. A second overlap is a request arriving during the indirect wait cycle. The scoreboard judges this by the absence of any extra result or read.

// File: rtl/regwin_pkg.sv
// Package: shared widths and the map-mode type for the register window translator.
// Assumes a 4-bit register number whose bits 2 and 3 feed the bank-select logic.
package regwin_pkg;
    localparam int REG_W   = 4;
    localparam int ADDR_W  = 10;
    localparam int BASE_W  = 6;
    localparam int MODE_W  = 3;
    localparam int FIELD_W = 10;

    typedef enum logic [MODE_W-1:0] {
        MAP_LO0  = 3'd0,
        MAP_LO1  = 3'd1,
        MAP_LO2  = 3'd2,
        MAP_LO3  = 3'd3,
        MAP_HI   = 3'd4,
        MAP_NHI  = 3'd5,
        MAP_AND  = 3'd6,
        MAP_OR   = 3'd7
    } map_mode_e;
endpackage

// File: rtl/regwin_ctrl.sv
// Module: holds the window base and the map mode, each written by its own strobe.
// Assumes the control field is stable while a strobe is high; reset clears both.
module regwin_ctrl
    import regwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_ld,
    input  logic               map_ld,
    input  logic [FIELD_W-1:0] ctl_field,
    output logic [BASE_W-1:0]  base_q,
    output map_mode_e          mode_q
);
    // Capture base and mode from the low bits of the control field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= MAP_LO0;
        end else begin
            if (base_ld) base_q <= ctl_field[BASE_W-1:0];
            if (map_ld)  mode_q <= map_mode_e'(ctl_field[MODE_W-1:0]);
        end
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ld |=> $stable(base_q)); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !map_ld |=> $stable(mode_q)); // R6
endmodule

// File: rtl/regwin_map.sv
// Module: combinational register-number to address mapping with window XOR.
// Assumes REG_W is 4 and ADDR_W is 10; the base covers address bits 7:2.
module regwin_map
    import regwin_pkg::*;
(
    input  logic [REG_W-1:0]  reg_num,
    input  map_mode_e         mode,
    input  logic [BASE_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);
    localparam int MID_W = ADDR_W - 2 - 3;

    logic              bank_bit;
    logic [ADDR_W-1:0] mapped;
    logic [ADDR_W-1:0] window;

    // Select the bank bit from register bits 2 and 3 according to the mode.
    always_comb begin
        case (mode)
            MAP_HI:  bank_bit = reg_num[3];
            MAP_NHI: bank_bit = ~reg_num[3];
            MAP_AND: bank_bit = reg_num[2] & reg_num[3];
            MAP_OR:  bank_bit = reg_num[2] | reg_num[3];
            default: bank_bit = reg_num[2];
        endcase
    end

    // Assemble the mapped address and fold in the scaled base.
    always_comb begin
        mapped = {reg_num[3], bank_bit, {MID_W{1'b0}}, reg_num[2:0]};
        window = {{(ADDR_W-BASE_W-2){1'b0}}, base, 2'b00};
        addr   = mapped ^ window;
    end

    // Check that the base never disturbs the bits it does not cover.
    always_comb begin
        AST_TOP_BIT: assert (addr[9] == reg_num[3]);        // R1
        AST_LOW_BITS: assert (addr[1:0] == reg_num[1:0]);   // R5
    end
endmodule

// File: rtl/regwin_ind.sv
// Module: request sequencing; direct results pass straight through, indirect
// ones issue one memory read and return the low bits of the read word.
// Assumes memory data arrives exactly one cycle after the read strobe.
module regwin_ind
    import regwin_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_req,
    input  logic              op_ind,
    input  logic [ADDR_W-1:0] xl_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic              busy
);
    logic wait_q;
    logic accept;

    // Accept a request only while no indirect read is outstanding.
    always_comb begin
        accept      = op_req && !wait_q;
        mem_rd_en   = accept && op_ind;
        mem_rd_addr = xl_addr;
        res_valid   = (accept && !op_ind) || wait_q;
        res_addr    = wait_q ? mem_rd_data[ADDR_W-1:0] : xl_addr;
        busy        = wait_q;
    end

    // Track the single wait cycle of an indirect translation.
    always_ff @(posedge clk) begin
        if (!rst_n) wait_q <= 1'b0;
        else        wait_q <= accept && op_ind;
    end

    AST_DIRECT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ind && !busy) |-> (res_valid && !mem_rd_en)); // R8
    AST_READ_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (res_valid && busy)); // R9
    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_rd_en); // R10
    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R10
endmodule

// File: rtl/regwin_xlate.sv
// Module: top of the banked register address translator.
// Assumes a synchronous memory read port with one cycle of latency.
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_ld,
    input  logic               map_ld,
    input  logic [FIELD_W-1:0] ctl_field,
    input  logic               op_req,
    input  logic [REG_W-1:0]   op_reg,
    input  logic               op_ind,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  res_addr,
    output logic               busy
);
    logic [BASE_W-1:0] base_q;
    map_mode_e         mode_q;
    logic [ADDR_W-1:0] xl_addr;

    regwin_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_ld   (base_ld),
        .map_ld    (map_ld),
        .ctl_field (ctl_field),
        .base_q    (base_q),
        .mode_q    (mode_q)
    );

    regwin_map u_map (
        .reg_num (op_reg),
        .mode    (mode_q),
        .base    (base_q),
        .addr    (xl_addr)
    );

    regwin_ind #(.DATA_W(DATA_W)) u_ind (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_req      (op_req),
        .op_ind      (op_ind),
        .xl_addr     (xl_addr),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .res_valid   (res_valid),
        .res_addr    (res_addr),
        .busy        (busy)
    );
endmodule

// File: tb/sim_regwin_xlate.sv
`timescale 1ns/1ps
module sim_regwin_xlate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_ld = 1'b0;
    logic       map_ld = 1'b0;
    logic [9:0] ctl_field = '0;
    logic       op_req = 1'b0;
    logic [3:0] op_reg = '0;
    logic       op_ind = 1'b0;
    logic       mem_rd_en;
    logic [9:0] mem_rd_addr;
    logic [15:0] mem_q = '0;
    logic       res_valid;
    logic [9:0] res_addr;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [5:0] sh_base = '0;
    logic [2:0] sh_mode = '0;

    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] rd_q[$];

    always #2 clk = ~clk;

    regwin_xlate u0 (
        .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .map_ld(map_ld),
        .ctl_field(ctl_field), .op_req(op_req), .op_reg(op_reg), .op_ind(op_ind),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_q),
        .res_valid(res_valid), .res_addr(res_addr), .busy(busy)
    );

    function automatic logic [15:0] memf(input logic [9:0] a);
        logic [9:0] v;
        v = a * 10'd7 + 10'd3;
        return {6'b101101, v};
    endfunction

    function automatic logic [9:0] model(input logic [3:0] r, input logic [2:0] m,
                                         input logic [5:0] b);
        logic s;
        case (m)
            3'd4: s = r[3];
            3'd5: s = ~r[3];
            3'd6: s = r[2] & r[3];
            3'd7: s = r[2] | r[3];
            default: s = r[2];
        endcase
        return {r[3], s, 5'b0, r[2:0]} ^ {2'b0, b, 2'b0};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_q <= memf(mem_rd_addr);

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read addresses and results as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_rd_en) begin
                if (rd_q.size() == 0) check("R10 unexpected read", mem_rd_addr, 10'h3FF ^ mem_rd_addr);
                else check("R9 read address", mem_rd_addr, rd_q.pop_front());
            end
            if (res_valid) begin
                if (exp_q.size() == 0) check("R10 unexpected result", res_addr, 10'h3FF ^ res_addr);
                else check(tag_q.pop_front(), res_addr, exp_q.pop_front());
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: presents a request and pushes what it must yield.
    task automatic push_op(input logic [3:0] r, input logic ind, input string tag);
        logic [9:0] t;
        op_req = 1'b1; op_reg = r; op_ind = ind;
        t = model(r, sh_mode, sh_base);
        if (ind) begin
            rd_q.push_back(t);
            exp_q.push_back(memf(t)[9:0]);
        end else begin
            exp_q.push_back(t);
        end
        tag_q.push_back(tag);
    endtask

    task automatic op(input logic [3:0] r, input logic ind, input string tag);
        push_op(r, ind, tag);
        step();
        op_req = 1'b0;
        if (ind) step();
    endtask

    task automatic ld(input logic do_base, input logic do_map, input logic [9:0] f);
        base_ld = do_base; map_ld = do_map; ctl_field = f;
        step();
        base_ld = 1'b0; map_ld = 1'b0;
        if (do_base) sh_base = f[5:0];
        if (do_map)  sh_mode = f[2:0];
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R7: idle outputs during reset
        check("R7 valid in reset", {9'b0, res_valid}, 10'd0);
        check("R7 read in reset", {9'b0, mem_rd_en}, 10'd0);
        check("R7 busy in reset", {9'b0, busy}, 10'd0);
        rst_n = 1'b1;
        step();
        // R7: base 0, mode 0 gives 0x105 for register 5
        op(4'd5, 1'b0, "R7 reset window");
        check("R7 model", model(4'd5, 3'd0, 6'd0), 10'h105);

        // R1 R2 R3 R4: every mode and register with base zero
        for (int m = 0; m < 8; m++) begin
            ld(1'b0, 1'b1, 10'(m));
            for (int r = 0; r < 16; r++)
                op(4'(r), 1'b0, m < 4 ? "R2 low modes" : (m < 6 ? "R3 bit3 modes" : "R4 and/or modes"));
        end
        op(4'd9, 1'b0, "R1 bit9 from bit3");

        // R5 R6: base applied with upper field bits set and ignored
        ld(1'b1, 1'b0, 10'h3C0 | 10'h15);
        for (int r = 0; r < 16; r++) op(4'(r), 1'b0, "R5 base xor");
        ld(1'b0, 1'b1, 10'h3FD);
        for (int r = 0; r < 16; r++) op(4'(r), 1'b0, "R6 mode low bits");
        ld(1'b1, 1'b0, 10'h03F);
        op(4'hF, 1'b0, "R5 full base");

        // R8 R9: direct and indirect back to back
        op(4'd3, 1'b1, "R9 indirect result");
        op(4'd3, 1'b0, "R8 direct result");
        op(4'hC, 1'b1, "R9 indirect result");
        op(4'hC, 1'b1, "R9 indirect repeat");

        // R10: request held during the wait cycle is ignored
        push_op(4'd6, 1'b1, "R10 indirect before ignore");
        step();
        check("R10 busy in wait", {9'b0, busy}, 10'd1);
        op_req = 1'b1; op_reg = 4'd1; op_ind = 1'b1;
        step();
        op_req = 1'b0;
        step();
        step();

        // R11: loads in the same cycle as a request use the old window
        base_ld = 1'b1; ctl_field = 10'h02A;
        push_op(4'd7, 1'b0, "R11 base load same cycle");
        step();
        op_req = 1'b0; base_ld = 1'b0; sh_base = 6'h2A;
        op(4'd7, 1'b0, "R11 new base next cycle");
        map_ld = 1'b1; ctl_field = 10'h004;
        push_op(4'hB, 1'b1, "R11 map load with indirect");
        step();
        op_req = 1'b0; map_ld = 1'b0; sh_mode = 3'd4;
        step();
        op(4'hB, 1'b1, "R11 new map next cycle");
        base_ld = 1'b1; map_ld = 1'b1; ctl_field = 10'h016;
        push_op(4'd4, 1'b0, "R11 both loads same cycle");
        step();
        op_req = 1'b0; base_ld = 1'b0; map_ld = 1'b0;
        sh_base = 6'h16; sh_mode = 3'd6;
        op(4'd4, 1'b0, "R11 both new next cycle");

        // R7: synchronous reset clears the window again
        rst_n = 1'b0; step(); rst_n = 1'b1; sh_base = '0; sh_mode = '0;
        op(4'hE, 1'b0, "R7 window after second reset");

        step(); step();
        check("R9 result queue drained", 10'(exp_q.size()), 10'd0);
        check("R9 read queue drained", 10'(rd_q.size()), 10'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule